// File: doc/BRIEF.md
# Polyphase Vertical Line-Rate Converter

This block changes the number of lines in a video field by a ratio of 5:6 or 6:5. It does this with a vertical polyphase FIR filter. Pixels arrive one per accepted cycle in raster order. Each input pixel is written into a ring of on-chip line delays. In the same cycle it is combined with the pixels in the same column of earlier lines. The coefficients for that sum are picked by the current line phase and by the field being produced.

In insert mode, each group of five input lines produces six output lines. After the fifth line of a group, the block holds off its input for one line time and builds an extra output line from the stored lines alone. In remove mode, each group of six input lines produces five output lines: the sixth line is stored but never emitted.

The same delay storage is split in one of two ways:
- CIF: full-width lines, four delays, a 5-tap filter.
- QCIF: half-width lines, six delays, a 7-tap filter.

The line-delay split and the direction are taken only at the start of an even field, which marks a frame start. Coefficients are loaded through a simple write port. There is one set per field, per phase and per tap.

Top module: `vline_rate_conv`

## Requirements
- R1: While reset is asserted and right after it is released, in_ready is 1 and out_valid is 0. Reset selects CIF, insert mode and field 0.
- R2: In CIF mode a line is LINE_W pixels long and the filter uses 5 taps. Tap k, for k from 0 to 4, is the pixel in the same column k lines earlier; tap 0 is the incoming pixel. Coefficient taps 5 and 6 have no effect.
- R3: In QCIF mode a line is LINE_W/2 pixels long and the filter uses 7 taps. Tap k, for k from 0 to 6, is the pixel in the same column k lines earlier.
- R4: Insert mode (cfg_remove=0). Input lines take phases 0 to 4 in turn. When the line with phase 4 completes, in_ready stays 0 for exactly one line time. During that time one output pixel is produced per cycle, using phase 5. In that inserted line, tap k reads the line min(k+1, D) back, where D is the number of delays (4 or 6). Phase 0 follows the inserted line.
- R5: Remove mode (cfg_remove=1). Input lines take phases 0 to 5 in turn. A pixel of a phase-5 line is accepted and stored, but it produces no output.
- R6: Writing to the coefficient port (coef_we=1) stores coef_wdata, a two's complement value, at set (coef_field, coef_phase, coef_tap). A write with coef_phase above 5 or coef_tap above 6 is ignored. Output lines use the set of the field given by field_sel at the last field_start.
- R7: A pulse on field_start does all of the following:
  - resets the phase and the column to 0;
  - cancels a pending inserted line;
  - causes pix_valid to be ignored in that cycle;
  - causes no output in that cycle.
- R8: cfg_qcif and cfg_remove are latched only on a field_start with field_sel=0. Changes to them at any other time have no effect.
- R9: Every accepted pixel that is not removed gives out_valid=1, with its result, on the next clock cycle.
- R10: The result is floor((sum of coef·pixel + 2^(FRAC-1)) / 2^FRAC), limited to the range 0 to 2^DATA_W−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_qcif | input | 1 | 1 selects the QCIF delay split, taken at frame start |
| cfg_remove | input | 1 | 1 selects line removal, 0 selects line insertion, taken at frame start |
| field_start | input | 1 | One-cycle pulse at a field boundary, given between lines |
| field_sel | input | 1 | Field number for the field that starts; 0 also marks a frame start |
| pix_valid | input | 1 | An input pixel is present |
| pix_data | input | DATA_W | Input pixel, unsigned |
| in_ready | output | 1 | Low while an inserted line is being produced |
| coef_we | input | 1 | Coefficient write strobe |
| coef_field | input | 1 | Coefficient field select |
| coef_phase | input | 3 | Coefficient phase, 0 to 5 |
| coef_tap | input | TW | Coefficient tap index, 0 to 6 |
| coef_wdata | input | COEF_W | Coefficient value, signed |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | DATA_W | Filtered output pixel |

## Verification
A wrong phase count first shows at in_ready. A stall that starts a line early or late, or a removed line that still emits, is visible within one line time of the fault. The fault also leaves every later output pixel weighted with the wrong coefficient row. A wrong ring slot or a wrong delay-split width shows in out_data on the first pixel whose window reaches that line, one cycle after the pixel is accepted. A mode or field latched at the wrong time changes the line length or the coefficient set on the next output line.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
    localparam int PHASES = 6;
    localparam int PH_W   = 3;
    localparam logic [PH_W-1:0] PH_LAST = 3'd5;  // inserted line, or removed line
    localparam logic [PH_W-1:0] PH_PRE  = 3'd4;  // last real line of an insert group

    typedef struct packed {
        logic qcif;
        logic remove;
    } mode_t;
endpackage

// File: rtl/vlr_seq.sv
module vlr_seq
    import vlr_pkg::*;
#(
    parameter  int LINE_W = 8,
    localparam int CW     = $clog2(LINE_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            field_start,
    input  logic            field_sel,
    input  logic            cfg_qcif,
    input  logic            cfg_remove,
    input  logic            pix_valid,
    output logic            in_ready,
    output logic            accept,
    output logic            emit,
    output logic            line_adv,
    output logic            frame_restart,
    output logic            ins,
    output logic            field,
    output logic            qcif,
    output logic            remove,
    output logic [CW-1:0]   col,
    output logic [PH_W-1:0] phase
);
    typedef struct packed {
        logic [CW-1:0]   col;
        logic [PH_W-1:0] phase;
        logic            ins;
        logic            field;
        mode_t           mode;
    } seq_t;

    seq_t          s_d, s_q;
    logic [CW-1:0] last_col;

    always_comb begin
        last_col      = s_q.mode.qcif ? CW'(LINE_W / 2 - 1) : CW'(LINE_W - 1);
        in_ready      = !s_q.ins;
        accept        = pix_valid && !s_q.ins && !field_start;
        line_adv      = accept && (s_q.col == last_col);
        emit          = !field_start &&
                        (s_q.ins || (accept && !(s_q.mode.remove && s_q.phase == PH_LAST)));
        frame_restart = field_start && !field_sel;
        s_d           = s_q;
        if (field_start) begin
            s_d.col   = '0;
            s_d.phase = '0;
            s_d.ins   = 1'b0;
            s_d.field = field_sel;
            if (!field_sel) begin
                s_d.mode.qcif   = cfg_qcif;
                s_d.mode.remove = cfg_remove;
            end
        end else if (s_q.ins) begin
            if (s_q.col == last_col) begin
                s_d.col   = '0;
                s_d.ins   = 1'b0;
                s_d.phase = '0;
            end else begin
                s_d.col = s_q.col + 1'b1;
            end
        end else if (accept) begin
            if (line_adv) begin
                s_d.col = '0;
                if (s_q.mode.remove) begin
                    s_d.phase = (s_q.phase == PH_LAST) ? '0 : s_q.phase + 1'b1;
                end else if (s_q.phase == PH_PRE) begin
                    s_d.phase = PH_LAST;
                    s_d.ins   = 1'b1;
                end else begin
                    s_d.phase = s_q.phase + 1'b1;
                end
            end else begin
                s_d.col = s_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ins    = s_q.ins;
    assign field  = s_q.field;
    assign qcif   = s_q.mode.qcif;
    assign remove = s_q.mode.remove;
    assign col    = s_q.col;
    assign phase  = s_q.phase;

    assert_field_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (s_q.col == '0 && s_q.phase == '0 && !s_q.ins));

    assert_ins_one_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ins && s_q.col == last_col && !field_start) |=> (!s_q.ins && s_q.phase == '0));

    assert_ins_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ins) |-> (s_q.phase == PH_LAST && !s_q.mode.remove));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(field_start && !field_sel) |=> $stable(s_q.mode));
endmodule

// File: rtl/vlr_ring.sv
module vlr_ring #(
    parameter  int DATA_W   = 8,
    parameter  int LINE_W   = 8,
    parameter  int CIF_DLY  = 4,
    parameter  int QCIF_DLY = 6,
    localparam int NT       = QCIF_DLY + 1,
    localparam int CW       = $clog2(LINE_W),
    localparam int DEPTH    = CIF_DLY * LINE_W,
    localparam int AW       = $clog2(DEPTH),
    localparam int SW       = $clog2(QCIF_DLY)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      qcif,
    input  logic                      wr_en,
    input  logic                      adv,
    input  logic                      ins,
    input  logic [CW-1:0]             col,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NT-1:0][DATA_W-1:0] taps
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [SW-1:0]     slot_d, slot_q;
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr [NT];
    int                ndly, wid;

    always_comb begin
        ndly    = qcif ? QCIF_DLY : CIF_DLY;
        wid     = qcif ? LINE_W / 2 : LINE_W;
        wr_addr = AW'(int'(slot_q) * wid + int'(col));
        slot_d  = slot_q;
        if (restart)  slot_d = '0;
        else if (adv) slot_d = (int'(slot_q) == ndly - 1) ? '0 : slot_q + 1'b1;
    end

    // Each tap picks a delay in lines; an inserted line sees only stored lines.
    for (genvar k = 0; k < NT; k++) begin : g_tap
        int dly, slot;
        always_comb begin
            dly        = ins ? ((k + 1 < ndly) ? k + 1 : ndly) : k;
            slot       = (int'(slot_q) >= dly) ? int'(slot_q) - dly : int'(slot_q) + ndly - dly;
            rd_addr[k] = AW'(slot * wid + int'(col));
            if (dly == 0)        taps[k] = wr_data;
            else if (dly > ndly) taps[k] = '0;
            else                 taps[k] = mem[rd_addr[k]];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (int'(slot_q) < (qcif ? QCIF_DLY : CIF_DLY)));
endmodule

// File: rtl/vlr_coef.sv
module vlr_coef
    import vlr_pkg::*;
#(
    parameter  int COEF_W = 8,
    parameter  int NT     = 7,
    localparam int TW     = $clog2(NT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic                      wfield,
    input  logic [PH_W-1:0]           wphase,
    input  logic [TW-1:0]             wtap,
    input  logic [COEF_W-1:0]         wdata,
    input  logic                      rfield,
    input  logic [PH_W-1:0]           rphase,
    output logic [NT-1:0][COEF_W-1:0] rset
);
    logic [1:0][PHASES-1:0][NT-1:0][COEF_W-1:0] c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we && int'(wphase) < PHASES && int'(wtap) < NT)
            c_d[wfield][wphase][wtap] = wdata;
        rset = c_q[rfield][rphase];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/vlr_mac.sv
module vlr_mac #(
    parameter  int DATA_W = 8,
    parameter  int COEF_W = 8,
    parameter  int FRAC   = 6,
    parameter  int NT     = 7,
    localparam int NW     = $clog2(NT + 1),
    localparam int ACC_W  = DATA_W + COEF_W + $clog2(NT) + 2
) (
    input  logic [NT-1:0][DATA_W-1:0] taps,
    input  logic [NT-1:0][COEF_W-1:0] coefs,
    input  logic [NW-1:0]             ntaps,
    output logic [DATA_W-1:0]         pix
);
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << DATA_W) - 1);

    logic signed [ACC_W-1:0] acc, scaled;

    always_comb begin
        acc = RND;
        for (int k = 0; k < NT; k++) begin
            if (k < int'(ntaps))
                acc = acc + ACC_W'($signed({1'b0, taps[k]})) * ACC_W'($signed(coefs[k]));
        end
        scaled = acc >>> FRAC;
        if (scaled < 0)         pix = '0;
        else if (scaled > MAXV) pix = MAXV[DATA_W-1:0];
        else                    pix = scaled[DATA_W-1:0];
    end
endmodule

// File: rtl/vline_rate_conv.sv
module vline_rate_conv
    import vlr_pkg::*;
#(
    parameter  int DATA_W   = 8,
    parameter  int COEF_W   = 8,
    parameter  int FRAC     = 6,
    parameter  int LINE_W   = 8,
    parameter  int CIF_DLY  = 4,
    parameter  int QCIF_DLY = 6,
    localparam int NT       = QCIF_DLY + 1,
    localparam int NW       = $clog2(NT + 1),
    localparam int TW       = $clog2(NT),
    localparam int CW       = $clog2(LINE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_qcif,
    input  logic              cfg_remove,
    input  logic              field_start,
    input  logic              field_sel,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              in_ready,
    input  logic              coef_we,
    input  logic              coef_field,
    input  logic [2:0]        coef_phase,
    input  logic [TW-1:0]     coef_tap,
    input  logic [COEF_W-1:0] coef_wdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_t;

    logic accept, emit, line_adv, frame_restart, ins, field, qcif, remove;
    logic [CW-1:0]             col;
    logic [PH_W-1:0]           phase;
    logic [NT-1:0][DATA_W-1:0] taps;
    logic [NT-1:0][COEF_W-1:0] coefs;
    logic [DATA_W-1:0]         mac_pix;
    logic [NW-1:0]             ntaps;
    out_t                      o_d, o_q;

    vlr_seq #(.LINE_W(LINE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .field_sel(field_sel),
        .cfg_qcif(cfg_qcif), .cfg_remove(cfg_remove), .pix_valid(pix_valid),
        .in_ready(in_ready), .accept(accept), .emit(emit), .line_adv(line_adv),
        .frame_restart(frame_restart), .ins(ins), .field(field), .qcif(qcif),
        .remove(remove), .col(col), .phase(phase)
    );

    vlr_ring #(.DATA_W(DATA_W), .LINE_W(LINE_W), .CIF_DLY(CIF_DLY), .QCIF_DLY(QCIF_DLY)) u_ring (
        .clk(clk), .rst_n(rst_n), .restart(frame_restart), .qcif(qcif), .wr_en(accept),
        .adv(line_adv), .ins(ins), .col(col), .wr_data(pix_data), .taps(taps)
    );

    vlr_coef #(.COEF_W(COEF_W), .NT(NT)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .wfield(coef_field), .wphase(coef_phase),
        .wtap(coef_tap), .wdata(coef_wdata), .rfield(field), .rphase(phase), .rset(coefs)
    );

    vlr_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC), .NT(NT)) u_mac (
        .taps(taps), .coefs(coefs), .ntaps(ntaps), .pix(mac_pix)
    );

    always_comb begin
        ntaps      = qcif ? NW'(QCIF_DLY + 1) : NW'(CIF_DLY + 1);
        o_d.valid  = emit;
        o_d.data   = emit ? mac_pix : o_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.valid;
    assign out_data  = o_q.data;

    assert_removed_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && remove && phase == PH_LAST) |=> !out_valid);

    assert_accept_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(remove && phase == PH_LAST)) |=> out_valid);

    assert_inserted_emits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && !field_start) |=> out_valid);

    assert_no_output_on_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !out_valid);
endmodule

// File: tb/vline_rate_conv_test.sv
`timescale 1ns/1ps
module vline_rate_conv_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_qcif = 1'b0, cfg_remove = 1'b0;
    logic       field_start = 1'b0, field_sel = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_data = '0;
    logic       in_ready;
    logic       coef_we = 1'b0, coef_field = 1'b0;
    logic [2:0] coef_phase = '0, coef_tap = '0;
    logic [7:0] coef_wdata = '0;
    logic       out_valid;
    logic [7:0] out_data;

    always #2.5 clk = ~clk;

    vline_rate_conv uut (
        .clk(clk), .rst_n(rst_n), .cfg_qcif(cfg_qcif), .cfg_remove(cfg_remove),
        .field_start(field_start), .field_sel(field_sel), .pix_valid(pix_valid),
        .pix_data(pix_data), .in_ready(in_ready), .coef_we(coef_we),
        .coef_field(coef_field), .coef_phase(coef_phase), .coef_tap(coef_tap),
        .coef_wdata(coef_wdata), .out_valid(out_valid), .out_data(out_data)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string ctx = "R2";
    int    cf [2][6][7];
    int    hist [64][8];
    int    m_col, m_phase, m_ins, m_field, m_qcif, m_remove, m_n, m_lf;

    task automatic check(int got, int exp, string tag, string what);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int exp_pix(int f, int p, int nt, int v[7]);
        int s = 32;
        for (int k = 0; k < nt; k++) s += cf[f][p][k] * v[k];
        s = s >>> 6;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    // One clock: drive at a falling edge, predict, then compare after the next falling edge.
    task automatic cyc(bit fs, bit fsel, bit pv, logic [7:0] pd);
        int w, dd, nt, dly, ln, ed;
        int v[7];
        bit acc, e, dchk;
        string tag;
        field_start = fs; field_sel = fsel; pix_valid = pv; pix_data = pd;
        w  = m_qcif ? 4 : 8;
        dd = m_qcif ? 6 : 4;
        nt = dd + 1;
        check(int'(in_ready), int'(!m_ins), "R4", "in_ready");
        acc  = pv && !m_ins && !fs;
        e    = !fs && (m_ins || (acc && !(m_remove && m_phase == 5)));
        dchk = e;
        ed   = 0;
        for (int k = 0; k < 7; k++) v[k] = 0;
        if (e) begin
            for (int k = 0; k < nt; k++) begin
                dly = m_ins ? ((k + 1 < dd) ? k + 1 : dd) : k;
                if (dly == 0) v[k] = int'(pd);
                else begin
                    ln = m_n - dly;
                    if (ln < 0) dchk = 0;
                    else v[k] = hist[ln][m_col];
                end
            end
            ed = exp_pix(m_field, m_phase, nt, v);
        end
        tag = m_ins ? "R4" : (fs ? "R7" : ((acc && m_remove && m_phase == 5) ? "R5" : "R9"));
        if (fs) begin
            m_col = 0; m_phase = 0; m_ins = 0; m_field = fsel; m_lf = 0;
            if (!fsel) begin m_qcif = cfg_qcif; m_remove = cfg_remove; m_n = 0; end
        end else if (m_ins) begin
            if (m_col == w - 1) begin m_col = 0; m_ins = 0; m_phase = 0; end
            else m_col++;
        end else if (acc) begin
            if (m_n < 64) hist[m_n][m_col] = int'(pd);
            if (m_col == w - 1) begin
                m_col = 0; m_n++; m_lf++;
                if (m_remove) m_phase = (m_phase == 5) ? 0 : m_phase + 1;
                else if (m_phase == 4) begin m_phase = 5; m_ins = 1; end
                else m_phase++;
            end else m_col++;
        end
        @(negedge clk);
        coef_we = 1'b0;
        check(int'(out_valid), int'(e), tag, "out_valid");
        if (dchk) check(int'(out_data), ed, (tag == "R4") ? "R4" : ctx, "out_data");
    endtask

    task automatic wr_coef(int f, int p, int t, int val);
        coef_we = 1'b1; coef_field = f[0]; coef_phase = p[2:0]; coef_tap = t[2:0];
        coef_wdata = val[7:0];
        if (p < 6 && t < 7) cf[f][p][t] = val;
        cyc(0, 0, 0, 8'd0);
    endtask

    task automatic run_lines(int n, int gap);
        int target = m_lf + n;
        while (m_lf < target || m_ins)
            cyc(0, 0, $urandom_range(0, 99) >= gap, 8'($urandom_range(0, 255)));
    endtask

    task automatic start_field(bit sel);
        cyc(1, sel, 1, 8'($urandom_range(0, 255)));  // pixel here must be ignored (R7)
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no end expected end");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_col = 0; m_phase = 0; m_ins = 0; m_field = 0; m_qcif = 0; m_remove = 0; m_n = 0; m_lf = 0;
        for (int f = 0; f < 2; f++) for (int p = 0; p < 6; p++) for (int t = 0; t < 7; t++) cf[f][p][t] = 0;
        repeat (3) @(negedge clk);
        check(int'(in_ready), 1, "R1", "in_ready in reset");
        check(int'(out_valid), 0, "R1", "out_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(in_ready), 1, "R1", "in_ready after reset");
        check(int'(out_valid), 0, "R1", "out_valid after reset");

        // Pass-through weights; reset mode is CIF insert, so data flows before any frame start (R1).
        for (int f = 0; f < 2; f++) for (int p = 0; p < 6; p++) for (int t = 0; t < 7; t++)
            wr_coef(f, p, t, (t == 0) ? 64 : 0);
        wr_coef(0, 6, 0, 100);           // out-of-range phase: ignored (R6)
        wr_coef(0, 0, 7, 100);           // out-of-range tap: ignored (R6)
        ctx = "R1"; run_lines(6, 10);

        // Random weights, both fields, all phases, all taps (R6).
        for (int f = 0; f < 2; f++) for (int p = 0; p < 6; p++) for (int t = 0; t < 7; t++)
            wr_coef(f, p, t, int'($urandom_range(0, 120)) - 40);

        ctx = "R2"; cfg_qcif = 0; cfg_remove = 0; start_field(0); run_lines(12, 20);
        ctx = "R6"; start_field(1); run_lines(11, 20);    // restart mid-group (R7)
        ctx = "R5"; cfg_remove = 1; start_field(0); run_lines(14, 15);
        ctx = "R7"; start_field(1); run_lines(9, 15);
        ctx = "R3"; cfg_qcif = 1; cfg_remove = 0; start_field(0); run_lines(13, 20);
        ctx = "R8"; cfg_qcif = 0; cfg_remove = 1; start_field(1); run_lines(8, 20);
        ctx = "R3"; cfg_qcif = 1; cfg_remove = 1; start_field(0); run_lines(14, 10);

        // Saturation at both ends (R10).
        ctx = "R10";
        for (int p = 0; p < 6; p++) for (int t = 0; t < 7; t++) wr_coef(0, p, t, 127);
        cfg_qcif = 0; cfg_remove = 0; start_field(0); run_lines(7, 0);
        for (int p = 0; p < 6; p++) for (int t = 0; t < 7; t++) wr_coef(0, p, t, -128);
        start_field(0); run_lines(7, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule